// File: doc/BRIEF.md
# Drawing Command Ring Parser

This block drains a circular queue of 32-bit command words that software places in a shared memory region. Four control words sit at the bottom of the region: the low and high byte bounds of the ring, the producer offset and the consumer offset. Whenever the device is switched on and its ring is configured, the parser reloads the control words. If the producer and consumer offsets differ, it pulls one complete command out of the ring. Each consumed word moves the consumer offset on by four bytes, folds it back to the low bound at the high bound, and writes it back to memory.

Commands the drawing engine understands leave the block one argument word per pulse on a drawing port, tagged with the opcode, the argument index and a last-word flag. Commands that are recognised but not executed have their arguments read and dropped, so the stream stays aligned. Some of those argument counts are fixed and some are computed from the command's own header words. A small set of opcodes does nothing. Any other opcode raises a one-cycle error pulse and is dropped on its own. A software sync request raises a busy flag that stays up until the parser finds the ring empty.

Top module: `cmd_ring_parser`

## Requirements
- R1: While reset is held and on the cycle after it, the parser makes no memory request, shows no drawing word, raises no error pulse and reports not busy.
- R2: The parser makes no memory request while the device is disabled or not configured. An enabled ring whose producer offset equals its consumer offset yields no drawing words and leaves the consumer offset unchanged.
- R3: Control words are the byte offsets at byte address 0 (low bound), 4 (high bound), 8 (producer) and 12 (consumer). Each consumed word comes from the consumer offset, which then grows by 4 and becomes the low bound if the result is at or above the high bound. The new offset is written to byte address 12 before the next word is read.
- R4: Opcodes 1 and 25 each emit 4 argument words (x, y, width, height) with indices 0 to 3, flagging index 3 as last.
- R5: Opcode 2 emits 5 argument words (colour, x, y, width, height). Opcode 3 emits 6 argument words (source x, source y, destination x, destination y, width, height). Both keep ring order and flag the final word.
- R6: Opcode 19 emits 7 header words (id, hot x, hot y, width w, height h, unused, bits per pixel b). It then emits ((w+31)>>5)*h mask words and ((w*b+31)>>5)*h image words, with indices running on from 7 and the final word flagged.
- R7: Opcodes 13, 14 and 28 emit nothing and consume 6, 7 and 12 argument words. The next command is then decoded correctly.
- R8: Opcode 24 consumes three header words and then 7 + (third header word >> 2) more. Opcode 22 consumes five header words and then (fourth × fifth header word) more. Neither emits anything.
- R9: Opcodes 0, 26, 27, 29 and 30 consume only themselves and have no effect. Any other 32-bit value in the opcode position gives exactly one single-cycle error pulse, consumes only itself, and emits nothing.
- R10: A sync request makes the busy flag read 1 on the following cycle. The flag clears once the parser finds the ring empty or the device off.
- R11: Memory requests last one cycle, and no new request is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Device switched on |
| config_i | input | 1 | Ring region configured |
| sync_i | input | 1 | Software sync request, sets busy |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | DATA_W | Write data (consumer offset) |
| mem_rvalid_i | input | 1 | Response for the outstanding request |
| mem_rdata_i | input | DATA_W | Read data with the response |
| draw_valid_o | output | 1 | An argument word is presented |
| draw_op_o | output | OP_W | Opcode of the command |
| draw_idx_o | output | IDX_W | Argument index within the command |
| draw_data_o | output | DATA_W | Argument word |
| draw_last_o | output | 1 | Final argument word of the command |
| err_o | output | 1 | One-cycle pulse for an unknown opcode |
| busy_o | output | 1 | Sync pending until the ring drains |

## Verification
Directed batches place each executed, skipped, idle and unknown opcode in the ring and follow it at once with an executed command. A wrong skip count or a missing opcode check then shows up as shifted or misread arguments in the following command. A disabled-device pass and an empty-ring pass show that the fetch is truly gated. Random batches mix commands with random arguments, random header sizes and random memory latency, so the consumer offset crosses the high bound at many alignments. This separates the wrap rule and the write-back from any fixed timing.

// File: rtl/cmdring_pkg.sv
// Shared types for the command ring parser.
// Assumes 32-bit words with byte-granular ring offsets.
package cmdring_pkg;

    // How the count of words after the fixed header is formed
    typedef enum logic [1:0] {
        TAIL_NONE,    // no extra words
        TAIL_CURSOR,  // mask plus image words of a cursor shape
        TAIL_AREA,    // width times height words
        TAIL_GLYPH    // seven plus a quarter of the third header word
    } tail_e;

    // What a parser does with an opcode
    typedef enum logic [1:0] {
        KIND_BAD,     // unknown, pulse error
        KIND_NOP,     // consumed, no effect
        KIND_EMIT,    // arguments go to the drawing port
        KIND_SKIP     // arguments read and dropped
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] hdr_len;
        tail_e      tail;
    } dec_t;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_HEADER,
        PH_TAIL
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL_REQ,
        ST_CTL_WAIT,
        ST_DAT_REQ,
        ST_DAT_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT
    } state_e;

endpackage

// File: rtl/cmdring_decode.sv
// Opcode classifier: maps a full command word to its handling kind,
// fixed header length and the rule for any trailing words.
// Assumes any value with bits above bit 4 set is unknown.
module cmdring_decode
    import cmdring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_i,
    output dec_t              dec_o
);

    // Classify the opcode word
    always_comb begin
        dec_o = '{kind: KIND_BAD, hdr_len: 4'd0, tail: TAIL_NONE};
        if (~|word_i[DATA_W-1:5]) begin
            unique case (word_i[4:0])
                5'd0, 5'd26, 5'd27, 5'd29, 5'd30:
                         dec_o = '{kind: KIND_NOP,  hdr_len: 4'd0,  tail: TAIL_NONE};
                5'd1, 5'd25:
                         dec_o = '{kind: KIND_EMIT, hdr_len: 4'd4,  tail: TAIL_NONE};
                5'd2:    dec_o = '{kind: KIND_EMIT, hdr_len: 4'd5,  tail: TAIL_NONE};
                5'd3:    dec_o = '{kind: KIND_EMIT, hdr_len: 4'd6,  tail: TAIL_NONE};
                5'd19:   dec_o = '{kind: KIND_EMIT, hdr_len: 4'd7,  tail: TAIL_CURSOR};
                5'd13:   dec_o = '{kind: KIND_SKIP, hdr_len: 4'd6,  tail: TAIL_NONE};
                5'd14:   dec_o = '{kind: KIND_SKIP, hdr_len: 4'd7,  tail: TAIL_NONE};
                5'd28:   dec_o = '{kind: KIND_SKIP, hdr_len: 4'd12, tail: TAIL_NONE};
                5'd24:   dec_o = '{kind: KIND_SKIP, hdr_len: 4'd3,  tail: TAIL_GLYPH};
                5'd22:   dec_o = '{kind: KIND_SKIP, hdr_len: 4'd5,  tail: TAIL_AREA};
                default: dec_o = '{kind: KIND_BAD,  hdr_len: 4'd0,  tail: TAIL_NONE};
            endcase
        end
    end

endmodule

// File: rtl/cmdring_tail.sv
// Trailing word count calculator. Evaluated while the last header
// word is on the read bus; cur_i is that word.
// Assumes wid_i/hgt_i already hold header words 3 and 4.
module cmdring_tail
    import cmdring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tail_e             rule_i,
    input  logic [DATA_W-1:0] wid_i,
    input  logic [DATA_W-1:0] hgt_i,
    input  logic [DATA_W-1:0] cur_i,
    output logic [DATA_W-1:0] cnt_o
);

    localparam logic [DATA_W-1:0] ROUND = DATA_W'(31);

    logic [DATA_W-1:0] mask_rows;
    logic [DATA_W-1:0] img_rows;

    // Per-row word counts of a cursor shape (cur_i is bits per pixel)
    always_comb begin
        mask_rows = (wid_i + ROUND) >> 5;
        img_rows  = ((wid_i * cur_i) + ROUND) >> 5;
    end

    // Select the count by rule
    always_comb begin
        unique case (rule_i)
            TAIL_CURSOR: cnt_o = (mask_rows * hgt_i) + (img_rows * hgt_i);
            TAIL_AREA:   cnt_o = wid_i * cur_i;
            TAIL_GLYPH:  cnt_o = DATA_W'(7) + (cur_i >> 2);
            default:     cnt_o = '0;
        endcase
    end

endmodule

// File: rtl/cmdring_ptr.sv
// Consumer offset stepper: advances by one word and folds back to
// the low bound when the result reaches the high bound.
module cmdring_ptr #(
    parameter int DATA_W = 32,
    parameter int STEP   = 4
) (
    input  logic [DATA_W-1:0] cur_i,
    input  logic [DATA_W-1:0] lower_i,
    input  logic [DATA_W-1:0] upper_i,
    output logic [DATA_W-1:0] next_o
);

    logic [DATA_W-1:0] stepped;

    // Step and wrap
    always_comb begin
        stepped = cur_i + DATA_W'(STEP);
        next_o  = (stepped >= upper_i) ? lower_i : stepped;
    end

endmodule

// File: rtl/cmd_ring_parser.sv
// Command ring parser top. Polls the four control words, and when the
// ring holds data consumes one whole command word by word, writing the
// consumer offset back after each word. Supported commands stream
// their arguments to the drawing port; the rest are skipped or flagged.
// Assumes one outstanding memory access and a response per request
// (writes included). The producer is only advanced past whole commands.
module cmd_ring_parser
    import cmdring_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 16,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              config_i,
    input  logic              sync_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              draw_valid_o,
    output logic [OP_W-1:0]   draw_op_o,
    output logic [IDX_W-1:0]  draw_idx_o,
    output logic [DATA_W-1:0] draw_data_o,
    output logic              draw_last_o,
    output logic              err_o,
    output logic              busy_o
);

    localparam int          WORD_BYTES = DATA_W / 8;
    localparam int          CONS_SLOT  = 3;
    localparam logic [ADDR_W-1:0] CONS_ADDR = ADDR_W'(CONS_SLOT * WORD_BYTES);

    state_e            state_q;
    phase_e            phase_q;
    logic [1:0]        slot_q;
    logic [DATA_W-1:0] lower_q, upper_q, prod_q, cons_q;
    logic [OP_W-1:0]   op_q;
    logic              emit_q;
    logic [3:0]        hdr_q;
    tail_e             rule_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rem_q, wid_q, hgt_q;
    logic              done_q;
    logic              busy_q;

    dec_t              dec;
    logic [DATA_W-1:0] tail_cnt;
    logic [DATA_W-1:0] cons_next;
    logic              running;
    logic              word_in;
    logic              hdr_end;
    logic              busy_clr;

    cmdring_decode #(.DATA_W(DATA_W)) u_decode (
        .word_i (mem_rdata_i),
        .dec_o  (dec)
    );

    cmdring_tail #(.DATA_W(DATA_W)) u_tail (
        .rule_i (rule_q),
        .wid_i  (wid_q),
        .hgt_i  (hgt_q),
        .cur_i  (mem_rdata_i),
        .cnt_o  (tail_cnt)
    );

    cmdring_ptr #(.DATA_W(DATA_W), .STEP(WORD_BYTES)) u_ptr (
        .cur_i   (cons_q),
        .lower_i (lower_q),
        .upper_i (upper_q),
        .next_o  (cons_next)
    );

    // Qualifiers shared by the sequencer and the busy flag
    always_comb begin
        running  = enable_i && config_i;
        word_in  = (state_q == ST_DAT_WAIT) && mem_rvalid_i;
        hdr_end  = (idx_q == IDX_W'(hdr_q - 4'd1));
        busy_clr = ((state_q == ST_IDLE) && !running) ||
                   ((state_q == ST_CTL_WAIT) && mem_rvalid_i &&
                    (slot_q == 2'(CONS_SLOT)) && (prod_q == mem_rdata_i));
    end

    // Memory request drive, derived from the sequencer state
    always_comb begin
        mem_req_o   = (state_q == ST_CTL_REQ) || (state_q == ST_DAT_REQ) ||
                      (state_q == ST_WB_REQ);
        mem_we_o    = (state_q == ST_WB_REQ);
        mem_wdata_o = cons_q;
        unique case (state_q)
            ST_CTL_REQ: mem_addr_o = ADDR_W'(slot_q) * ADDR_W'(WORD_BYTES);
            ST_DAT_REQ: mem_addr_o = cons_q[ADDR_W-1:0];
            ST_WB_REQ:  mem_addr_o = CONS_ADDR;
            default:    mem_addr_o = '0;
        endcase
    end

    // Sync-busy flag: a new request wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= sync_i || (busy_q && !busy_clr);
    end
    assign busy_o = busy_q;

    // Sequencer: control poll, word fetch, write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            lower_q <= '0;
            upper_q <= '0;
            prod_q  <= '0;
            cons_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (running) begin
                    slot_q  <= '0;
                    state_q <= ST_CTL_REQ;
                end
                ST_CTL_REQ: state_q <= ST_CTL_WAIT;
                ST_CTL_WAIT: if (mem_rvalid_i) begin
                    unique case (slot_q)
                        2'd0:    lower_q <= mem_rdata_i;
                        2'd1:    upper_q <= mem_rdata_i;
                        2'd2:    prod_q  <= mem_rdata_i;
                        default: cons_q  <= mem_rdata_i;
                    endcase
                    if (slot_q == 2'(CONS_SLOT))
                        state_q <= (prod_q == mem_rdata_i) ? ST_IDLE : ST_DAT_REQ;
                    else begin
                        slot_q  <= slot_q + 2'd1;
                        state_q <= ST_CTL_REQ;
                    end
                end
                ST_DAT_REQ: state_q <= ST_DAT_WAIT;
                ST_DAT_WAIT: if (mem_rvalid_i) begin
                    cons_q  <= cons_next;
                    state_q <= ST_WB_REQ;
                end
                ST_WB_REQ: state_q <= ST_WB_WAIT;
                ST_WB_WAIT: if (mem_rvalid_i)
                    state_q <= done_q ? ST_IDLE : ST_DAT_REQ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Command walker: opcode decode, header capture, tail counting, output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_OPCODE;
            op_q         <= '0;
            emit_q       <= 1'b0;
            hdr_q        <= '0;
            rule_q       <= TAIL_NONE;
            idx_q        <= '0;
            rem_q        <= '0;
            wid_q        <= '0;
            hgt_q        <= '0;
            done_q       <= 1'b0;
            draw_valid_o <= 1'b0;
            draw_op_o    <= '0;
            draw_idx_o   <= '0;
            draw_data_o  <= '0;
            draw_last_o  <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            draw_valid_o <= 1'b0;
            draw_last_o  <= 1'b0;
            err_o        <= 1'b0;
            if (state_q == ST_CTL_WAIT) phase_q <= PH_OPCODE;
            if (word_in) begin
                done_q      <= 1'b0;
                draw_op_o   <= op_q;
                draw_idx_o  <= idx_q;
                draw_data_o <= mem_rdata_i;
                unique case (phase_q)
                    PH_OPCODE: begin
                        op_q   <= mem_rdata_i[OP_W-1:0];
                        idx_q  <= '0;
                        emit_q <= (dec.kind == KIND_EMIT);
                        hdr_q  <= dec.hdr_len;
                        rule_q <= dec.tail;
                        if (dec.kind == KIND_BAD) begin
                            err_o  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (dec.kind == KIND_NOP)
                            done_q <= 1'b1;
                        else
                            phase_q <= PH_HEADER;
                    end
                    PH_HEADER: begin
                        draw_valid_o <= emit_q;
                        draw_last_o  <= emit_q && hdr_end && (tail_cnt == '0);
                        if (idx_q == IDX_W'(3)) wid_q <= mem_rdata_i;
                        if (idx_q == IDX_W'(4)) hgt_q <= mem_rdata_i;
                        idx_q <= idx_q + 1'b1;
                        if (hdr_end) begin
                            if (tail_cnt == '0) begin
                                done_q  <= 1'b1;
                                phase_q <= PH_OPCODE;
                            end else begin
                                rem_q   <= tail_cnt;
                                phase_q <= PH_TAIL;
                            end
                        end
                    end
                    default: begin
                        draw_valid_o <= emit_q;
                        draw_last_o  <= emit_q && (rem_q == DATA_W'(1));
                        idx_q <= idx_q + 1'b1;
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == DATA_W'(1)) begin
                            done_q  <= 1'b1;
                            phase_q <= PH_OPCODE;
                        end
                    end
                endcase
            end
        end
    end

    // R11: a request lasts one cycle and is followed by waiting
    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R2: no request is issued while the device is off
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !(enable_i && config_i)) |=> !mem_req_o);

    // R3: a consumer offset inside the ring stays inside after a step
    a_r3_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (word_in && (lower_q < upper_q) && (cons_q >= lower_q) && (cons_q < upper_q))
        |=> ((cons_q >= lower_q) && (cons_q < upper_q)));

    // R9: the unknown-opcode pulse lasts a single cycle
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R10: a sync request is visible as busy on the next cycle
    a_r10_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> busy_o);

    // R4: drawing words appear only right after a read response
    a_r4_draw_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        draw_valid_o |-> $past(mem_rvalid_i));

endmodule

// File: tb/test_cmd_ring_parser.sv
`timescale 1ns/1ps
module test_cmd_ring_parser;

    localparam int MEMW  = 64;
    localparam int LOWER = 16;
    localparam int UPPER = 176;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        config_i = 1'b0;
    logic        sync_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        draw_valid_o, draw_last_o, err_o, busy_o;
    logic [7:0]  draw_op_o;
    logic [15:0] draw_idx_o;
    logic [31:0] draw_data_o;

    int unsigned mem [MEMW];
    int checks = 0, errors = 0;
    int unsigned prod_b = LOWER;
    int unsigned eq_op[$], eq_idx[$], eq_dat[$], eq_last[$];
    int unsigned ob_op[$], ob_idx[$], ob_dat[$], ob_last[$];
    int err_seen = 0, req_cnt = 0, proto_err = 0, bad_wr = 0, exp_err = 0;

    cmd_ring_parser i_cmd_ring_parser (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .config_i(config_i),
        .sync_i(sync_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .draw_valid_o(draw_valid_o), .draw_op_o(draw_op_o),
        .draw_idx_o(draw_idx_o), .draw_data_o(draw_data_o),
        .draw_last_o(draw_last_o), .err_o(err_o), .busy_o(busy_o));

    initial forever #10 clk = ~clk;

    // Memory model and output monitor, all at the falling edge
    initial begin : mem_model
        bit pend = 0;
        bit p_we = 0;
        int lat = 0;
        int unsigned p_addr = 0;
        forever begin
            @(negedge clk);
            if (draw_valid_o) begin
                ob_op.push_back(draw_op_o);   ob_idx.push_back(draw_idx_o);
                ob_dat.push_back(draw_data_o); ob_last.push_back(draw_last_o);
            end
            if (err_o) err_seen++;
            mem_rvalid_i = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = (p_we || (p_addr / 4) >= MEMW) ? 32'd0 : mem[p_addr / 4];
                    pend = 0;
                end else lat--;
            end
            if (mem_req_o) begin
                req_cnt++;
                if (pend) proto_err++;
                pend = 1; lat = int'($urandom % 3);
                p_addr = mem_addr_o; p_we = mem_we_o;
                if (mem_we_o) begin
                    if (mem_addr_o != 16'd12) bad_wr++;
                    else mem[3] = mem_wdata_o;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int unsigned w);
        mem[prod_b / 4] = w;
        prod_b += 4;
        if (prod_b >= UPPER) prod_b = LOWER;
    endtask

    task automatic put_emit(input int unsigned op, input int unsigned idx,
                            input int unsigned w, input bit last);
        put(w);
        eq_op.push_back(op & 8'hff); eq_idx.push_back(idx);
        eq_dat.push_back(w); eq_last.push_back(last);
    endtask

    // Emitting command with n fixed random arguments (R4, R5)
    task automatic cmd_plain(input int unsigned op, input int n);
        put(op);
        for (int i = 0; i < n; i++) put_emit(op, i, $urandom, i == n - 1);
    endtask

    // Cursor shape: header then mask and image words (R6)
    task automatic cmd_cursor(input int unsigned w, input int unsigned h, input int unsigned bpp);
        int unsigned hdr[7];
        int unsigned tail;
        hdr = '{$urandom, $urandom, $urandom, w, h, $urandom, bpp};
        tail = ((w + 31) >> 5) * h + ((w * bpp + 31) >> 5) * h;
        put(19);
        for (int i = 0; i < 7; i++) put_emit(19, i, hdr[i], (i == 6) && (tail == 0));
        for (int i = 0; i < int'(tail); i++) put_emit(19, 7 + i, $urandom, i == int'(tail) - 1);
    endtask

    // Skipped commands (R7, R8)
    task automatic cmd_skip(input int unsigned op, input int n);
        put(op);
        for (int i = 0; i < n; i++) put($urandom);
    endtask

    task automatic cmd_glyph(input int unsigned third);
        put(24); put($urandom); put($urandom); put(third);
        for (int i = 0; i < int'(7 + (third >> 2)); i++) put($urandom);
    endtask

    task automatic cmd_alpha(input int unsigned w, input int unsigned h);
        put(22); put($urandom); put($urandom); put($urandom); put(w); put(h);
        for (int i = 0; i < int'(w * h); i++) put($urandom);
    endtask

    task automatic cmd_bad(input int unsigned op);
        put(op);
        exp_err++;
    endtask

    task automatic begin_batch;
        eq_op.delete(); eq_idx.delete(); eq_dat.delete(); eq_last.delete();
        ob_op.delete(); ob_idx.delete(); ob_dat.delete(); ob_last.delete();
        exp_err = 0;
    endtask

    // Publish the producer, request sync, wait for drain, compare
    task automatic run_batch(input string req);
        int e0;
        int t;
        e0 = err_seen;
        mem[2] = prod_b;
        repeat (30) @(negedge clk);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        chk(busy_o == 1'b1, "R10", "busy after sync", busy_o, 1);
        t = 0;
        while (busy_o && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R10", "busy cleared after drain", t, 0);
        chk(ob_op.size() == eq_op.size(), req, "draw word count", ob_op.size(), eq_op.size());
        for (int i = 0; i < eq_op.size() && i < ob_op.size(); i++) begin
            chk(ob_op[i] == eq_op[i], req, "opcode", ob_op[i], eq_op[i]);
            chk(ob_idx[i] == eq_idx[i] && ob_dat[i] == eq_dat[i], req, "arg data", ob_dat[i], eq_dat[i]);
            chk(ob_last[i] == eq_last[i], req, "last flag", ob_last[i], eq_last[i]);
        end
        chk(err_seen - e0 == exp_err, "R9", "error pulses", err_seen - e0, exp_err);
        chk(mem[3] == prod_b, "R3", "consumer written back", mem[3], prod_b);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int rc0;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEMW; i++) mem[i] = 0;
        mem[0] = LOWER; mem[1] = UPPER; mem[2] = LOWER; mem[3] = LOWER;
        repeat (4) @(negedge clk);
        chk(!mem_req_o && !draw_valid_o && !err_o && !busy_o, "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1; config_i = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !draw_valid_o && !err_o && !busy_o, "R1", "outputs after reset", 0, 0);

        // R2: disabled device ignores a filled ring
        begin_batch;
        cmd_plain(1, 4);
        mem[2] = prod_b;
        repeat (5) @(negedge clk);
        rc0 = req_cnt;
        sync_i = 1'b1; @(negedge clk); sync_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(req_cnt == rc0, "R2", "requests while disabled", req_cnt, rc0);
        chk(ob_op.size() == 0, "R2", "draw words while disabled", ob_op.size(), 0);
        chk(busy_o == 1'b0, "R10", "busy cleared while disabled", busy_o, 0);
        enable_i = 1'b1;
        run_batch("R4");

        // R2: enabled but empty ring
        begin_batch;
        run_batch("R2");

        begin_batch; cmd_plain(25, 4); cmd_plain(1, 4); run_batch("R4");
        begin_batch; cmd_plain(2, 5); cmd_plain(3, 6); run_batch("R5");
        begin_batch; cmd_cursor(40, 2, 8); run_batch("R6");
        begin_batch; cmd_cursor(5, 1, 1); cmd_cursor(0, 3, 8); run_batch("R6");
        begin_batch; cmd_skip(13, 6); cmd_plain(1, 4); run_batch("R7");
        begin_batch; cmd_skip(14, 7); cmd_plain(2, 5); run_batch("R7");
        begin_batch; cmd_skip(28, 12); cmd_plain(3, 6); run_batch("R7");
        begin_batch; cmd_glyph(20); cmd_plain(1, 4); run_batch("R8");
        begin_batch; cmd_alpha(3, 4); cmd_plain(2, 5); run_batch("R8");
        begin_batch; put(0); put(26); put(27); put(29); put(30); cmd_plain(1, 4); run_batch("R9");
        begin_batch; cmd_bad(5); cmd_bad(257); cmd_bad(31); cmd_plain(2, 5); run_batch("R9");

        // Random batches: mixed commands, wrapping many times (R3)
        for (int b = 0; b < 60; b++) begin
            begin_batch;
            for (int c = 0; c < 1 + int'($urandom % 2); c++) begin
                case ($urandom % 10)
                    0: cmd_plain(1, 4);
                    1: cmd_plain(25, 4);
                    2: cmd_plain(2, 5);
                    3: cmd_plain(3, 6);
                    4: cmd_cursor($urandom % 17, 1 + $urandom % 2, 1 << ($urandom % 3));
                    5: cmd_skip(28, 12);
                    6: cmd_glyph($urandom % 17);
                    7: cmd_alpha($urandom % 4, $urandom % 4);
                    8: put(30);
                    default: cmd_bad(6 + $urandom % 7);
                endcase
            end
            run_batch("R3");
        end

        chk(proto_err == 0, "R11", "overlapping requests", proto_err, 0);
        chk(bad_wr == 0, "R3", "writes outside consumer slot", bad_wr, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule